// File: doc/BRIEF.md
# Parallel Port Byte Receiver with Host Handshake

This block is the peripheral end of a byte-wide parallel link. A host presents a byte and pulses an active-low strobe. The receiver brings the strobe into the system clock domain and holds the byte when the strobe is released. It then raises a busy line toward the host, so the host sends nothing more until the local processor has dealt with the byte.

The processor reaches the block through a two-address register window. The data address returns the held byte, and reading it lowers the hardware half of busy. The control address holds a busy bit that the processor sets itself. Busy toward the host is the OR of the two halves, so the processor can keep the host waiting after it has taken the byte. Writing the acknowledge command produces a timed active-low acknowledge pulse toward the host. The processor then drops its own busy bit, and the port is ready for the next byte.

A status byte reports:
- that a byte is waiting;
- that a byte was overwritten;
- both busy halves;
- whether an acknowledge pulse is running.

An interrupt line follows the byte-waiting flag.

Top module: `par_rx_handshake`

## Requirements
- R1: After synchronous reset, `host_busy` is 0, `host_ack_n` is 1, `irq` is 0 and the status byte reads 0x00.
- R2: The byte held on `host_data` while `host_strobe_n` is low is captured when the strobe returns high. Reading address 0 returns that byte.
- R3: Capturing a byte sets the hardware busy flag, and `host_busy` is 1 within four clocks of the strobe rising.
- R4: A read of address 0 clears the hardware busy flag. `host_busy` then falls unless the software busy bit is set.
- R5: Writing address 1 loads bit 0 into the software busy bit. `host_busy` is the OR of the hardware busy flag and this bit.
- R6: A write to address 1 with bit 1 set drives `host_ack_n` low for exactly ACK_CYCLES clocks, starting the cycle after the write.
- R7: An acknowledge command issued while a pulse is running restarts the pulse, which then lasts ACK_CYCLES clocks from the later command.
- R8: The status byte at address 1 has these bits:
  - bit 0: byte waiting;
  - bit 1: overrun;
  - bit 2: hardware busy;
  - bit 3: software busy;
  - bit 4: acknowledge active;
  - bits 7..5: always 0.

  Bit 0 is set by a capture and cleared by a read of address 0. `irq` equals bit 0.
- R9: A capture while the hardware busy flag is still set replaces the held byte and sets the overrun bit. The overrun bit stays set until address 1 is read.
- R10: A write to address 1 with bit 1 clear causes no acknowledge pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_strobe_n | input | 1 | Host data strobe, active low, asynchronous |
| host_data | input | 8 | Host data byte |
| host_busy | output | 1 | Busy toward the host |
| host_ack_n | output | 1 | Acknowledge toward the host, active low |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = data byte, 1 = control/status |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the addressed register |
| irq | output | 1 | Byte-waiting interrupt |

## Verification
The assertions assume the host protocol is respected:
- the strobe stays low for at least two system clocks;
- the data lines stay stable until two clocks after the strobe rises;
- a register access lasts one clock.

The bench holds the strobe low for three clocks and keeps the byte for three clocks after release. It issues every bus access as a single-cycle pulse.

Random bytes and random software-busy settings are mixed with deliberate back-to-back strobes. These exercise the overrun path without breaking those timing limits.

// File: rtl/pp_rx_pkg.sv
package pp_rx_pkg;

    typedef enum logic {
        REG_DATA = 1'b0,
        REG_CTRL = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic [5:0] spare;
        logic       ack_req;
        logic       sw_busy;
    } ctrl_wr_t;

    typedef struct packed {
        logic [2:0] zero;
        logic       ack_active;
        logic       sw_busy;
        logic       hw_busy;
        logic       overrun;
        logic       avail;
    } rx_status_t;

    function automatic logic bus_hit(logic sel, logic wr, logic want_wr,
                                     logic addr, reg_sel_e want_addr);
        return sel && (wr == want_wr) && (reg_sel_e'(addr) == want_addr);
    endfunction

endpackage

// File: rtl/pp_strobe_sync.sv
module pp_strobe_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe_n,
    output logic strobe_low,
    output logic strobe_rise
);
    logic [SYNC_STAGES:0] shift_q;

    always_ff @(posedge clk) begin
        if (rst) shift_q <= '1;
        else     shift_q <= {shift_q[SYNC_STAGES-1:0], strobe_n};
    end

    assign strobe_low  = ~shift_q[SYNC_STAGES-1];
    assign strobe_rise = shift_q[SYNC_STAGES-1] & ~shift_q[SYNC_STAGES];

    // R2
    rise_after_low_chk: assert property (@(posedge clk) disable iff (rst)
        strobe_rise |-> $past(strobe_low));

endmodule

// File: rtl/pp_ack_timer.sv
module pp_ack_timer #(
    parameter int ACK_CYCLES = 250
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic active,
    output logic ack_n
);
    localparam int CW = $clog2(ACK_CYCLES + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)               cnt_q <= '0;
        else if (fire)         cnt_q <= CW'(ACK_CYCLES);
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign active = (cnt_q != '0);
    assign ack_n  = ~active;

    // R6
    ack_starts_chk: assert property (@(posedge clk) disable iff (rst)
        fire |=> !ack_n);

    // R6
    ack_ends_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ack_n) |-> ($past(cnt_q) == CW'(1) && !$past(fire)));

endmodule

// File: rtl/par_rx_handshake.sv
module par_rx_handshake
    import pp_rx_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int ACK_CYCLES  = 250,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_strobe_n,
    input  logic [DATA_W-1:0] host_data,
    output logic              host_busy,
    output logic              host_ack_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              irq
);
    logic              stb_low, stb_rise;
    logic [DATA_W-1:0] shadow_q, hold_q;
    logic              hw_busy_q, sw_busy_q, avail_q, ovr_q;
    logic              ack_active;
    logic              rd_data, rd_stat, wr_ctrl, clash;
    ctrl_wr_t          ctrl_w;
    rx_status_t        stat;

    pp_strobe_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .strobe_n   (host_strobe_n),
        .strobe_low (stb_low),
        .strobe_rise(stb_rise)
    );

    assign ctrl_w  = ctrl_wr_t'(bus_wdata);
    assign rd_data = bus_hit(bus_sel, bus_wr, 1'b0, bus_addr, REG_DATA);
    assign rd_stat = bus_hit(bus_sel, bus_wr, 1'b0, bus_addr, REG_CTRL);
    assign wr_ctrl = bus_hit(bus_sel, bus_wr, 1'b1, bus_addr, REG_CTRL);
    assign clash   = stb_rise && hw_busy_q && !rd_data;

    pp_ack_timer #(.ACK_CYCLES(ACK_CYCLES)) u_ack (
        .clk   (clk),
        .rst   (rst),
        .fire  (wr_ctrl && ctrl_w.ack_req),
        .active(ack_active),
        .ack_n (host_ack_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
        end else if (stb_low) begin
            shadow_q <= host_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q    <= '0;
            hw_busy_q <= 1'b0;
            avail_q   <= 1'b0;
            ovr_q     <= 1'b0;
            sw_busy_q <= 1'b0;
        end else begin
            if (stb_rise) begin
                hold_q    <= shadow_q;
                hw_busy_q <= 1'b1;
                avail_q   <= 1'b1;
            end else if (rd_data) begin
                hw_busy_q <= 1'b0;
                avail_q   <= 1'b0;
            end
            if (rd_stat) ovr_q <= 1'b0;
            if (clash)   ovr_q <= 1'b1;
            if (wr_ctrl) sw_busy_q <= ctrl_w.sw_busy;
        end
    end

    always_comb begin
        stat            = '0;
        stat.avail      = avail_q;
        stat.overrun    = ovr_q;
        stat.hw_busy    = hw_busy_q;
        stat.sw_busy    = sw_busy_q;
        stat.ack_active = ack_active;
    end

    assign bus_rdata = (reg_sel_e'(bus_addr) == REG_CTRL) ? 8'(stat) : 8'(hold_q);
    assign host_busy = hw_busy_q | sw_busy_q;
    assign irq       = avail_q;

    // R3
    busy_on_latch_chk: assert property (@(posedge clk) disable iff (rst)
        stb_rise |=> host_busy);

    // R4
    read_clears_hw_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_data && !stb_rise) |=> (!hw_busy_q && !irq));

    // R5
    sw_holds_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && ctrl_w.sw_busy) |=> host_busy);

    // R9
    overrun_set_chk: assert property (@(posedge clk) disable iff (rst)
        (stb_rise && $past(stb_rise) == 1'b0 && hw_busy_q && !rd_data) |=> ovr_q);

    // R10
    no_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && !ctrl_w.ack_req && host_ack_n) |=> host_ack_n);

endmodule

// File: tb/par_rx_handshake_bench.sv
module par_rx_handshake_bench;

    localparam int N = 12;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_strobe_n = 1'b1;
    logic [7:0] host_data = '0;
    logic       host_busy, host_ack_n, irq;
    logic       bus_sel = 1'b0, bus_wr = 1'b0, bus_addr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    logic       m_avail = 0, m_ovr = 0, m_hw = 0, m_sw = 0;
    logic [7:0] m_data = '0;

    always #10 clk = ~clk;

    par_rx_handshake #(.ACK_CYCLES(N)) u_par_rx_handshake (
        .clk(clk), .rst(rst), .host_strobe_n(host_strobe_n), .host_data(host_data),
        .host_busy(host_busy), .host_ack_n(host_ack_n), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    function automatic logic [7:0] exp_status(logic av, logic ov, logic hw, logic sw, logic ack);
        return {3'b000, ack, sw, hw, ov, av};
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic a, logic [7:0] d);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
        if (a) m_sw = d[0];
    endtask

    task automatic bus_read(logic a, output logic [7:0] d);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #5 d = bus_rdata;
        @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic send_byte(logic [7:0] b);
        host_data = b; host_strobe_n = 0;
        repeat (3) @(negedge clk);
        host_strobe_n = 1;
        repeat (3) @(negedge clk);
        host_data = ~b;
        repeat (2) @(negedge clk);
        if (m_hw) m_ovr = 1;
        m_data = b; m_hw = 1; m_avail = 1;
    endtask

    task automatic read_status_chk(string req);
        logic [7:0] v;
        bus_read(1'b1, v);
        chk(req, v, exp_status(m_avail, m_ovr, m_hw, m_sw, 1'b0));
        m_ovr = 0;
    endtask

    task automatic read_data_chk(string req);
        logic [7:0] v;
        bus_read(1'b0, v);
        chk(req, v, m_data);
        m_hw = 0; m_avail = 0;
    endtask

    task automatic count_low(output int c);
        c = 0;
        while (!host_ack_n && c < 1000) begin
            c++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        int c;
        logic [7:0] v;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1 reset state
        chk("R1 busy", 8'(host_busy), 8'd0);
        chk("R1 ack_n", 8'(host_ack_n), 8'd1);
        chk("R1 irq", 8'(irq), 8'd0);
        read_status_chk("R1 status");

        // R2 R3 R8 directed capture
        send_byte(8'hA5);
        chk("R3 busy after latch", 8'(host_busy), 8'd1);
        chk("R8 irq set", 8'(irq), 8'd1);
        read_status_chk("R8 status after latch");
        read_data_chk("R2 data");
        chk("R4 busy cleared", 8'(host_busy), 8'd0);
        chk("R8 irq cleared", 8'(irq), 8'd0);

        // R5 software busy
        bus_write(1'b1, 8'h01);
        chk("R5 sw busy", 8'(host_busy), 8'd1);
        send_byte(8'h3C);
        read_data_chk("R2 data with sw busy");
        chk("R5 busy held after read", 8'(host_busy), 8'd1);
        bus_write(1'b1, 8'h00);
        chk("R5 busy released", 8'(host_busy), 8'd0);

        // R6 pulse width
        bus_write(1'b1, 8'h02);
        count_low(c);
        chk("R6 ack width", 8'(c), 8'(N));

        // R8 ack-active status bit
        bus_write(1'b1, 8'h02);
        bus_read(1'b1, v);
        chk("R8 ack bit", v, exp_status(0, 0, 0, 0, 1));
        repeat (N + 2) @(negedge clk);
        chk("R6 ack over", 8'(host_ack_n), 8'd1);

        // R7 restart
        bus_write(1'b1, 8'h02);
        repeat (5) @(negedge clk);
        chk("R7 still low", 8'(host_ack_n), 8'd0);
        bus_write(1'b1, 8'h02);
        count_low(c);
        chk("R7 restarted width", 8'(c), 8'(N));

        // R10 no pulse without command bit
        bus_write(1'b1, 8'h00);
        c = 0;
        repeat (N + 2) begin
            if (!host_ack_n) c++;
            @(negedge clk);
        end
        chk("R10 no ack", 8'(c), 8'd0);

        // R9 overrun
        send_byte(8'h11);
        send_byte(8'h22);
        read_status_chk("R9 overrun set");
        read_status_chk("R9 overrun cleared by status read");
        read_data_chk("R9 newest byte kept");

        // random traffic
        for (int i = 0; i < 60; i++) begin
            logic [7:0] b;
            logic sw;
            b  = 8'($urandom);
            sw = 1'($urandom);
            bus_write(1'b1, {7'd0, sw});
            send_byte(b);
            if ($urandom % 4 == 0) send_byte(8'($urandom));
            chk("R3 random busy", 8'(host_busy), 8'd1);
            read_status_chk("R8 R9 random status");
            read_data_chk("R2 random data");
            chk("R4 R5 random busy", 8'(host_busy), 8'(m_sw));
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule